// File: doc/BRIEF.md
# Codec Response Ring Writer

This block sits between the codec link and system memory on the response side of an audio controller. Each codec response arrives as a 32-bit word, a flag telling solicited from unsolicited traffic, and the 4-bit address of the codec that sent it. If software has an immediate command outstanding, the response is parked in an immediate-response register and the immediate status is updated. Otherwise, and only while ring transfers are enabled, the response becomes one 8-byte entry in a 256-entry ring in memory. The entry holds the response word followed by an extended word that carries the codec address and the unsolicited flag.

The block owns the ring write pointer and a response counter. It raises a ring interrupt status bit when the counter reaches a programmed threshold, or when the command side reports that its ring has drained. In both cases the interrupt enable must be set. Software reaches the control, status, pointer, threshold, base and immediate registers through a simple register port. Memory writes leave through a request/grant port, one 32-bit write at a time.

Top module: `response_ring_writer`

## Requirements
- R1: When immediate-busy (bit 0 of register 5) is set, an accepted response makes no memory write. Register 6 takes the response word, busy clears, valid (bit 1 of register 5) sets, and bits 7:4 of register 5 take the codec address. Writing 1 to bit 0 of register 5 sets busy, and writing 1 to bit 1 clears valid.
- R2: When busy is clear and the ring enable (bit 0 of register 0) is clear, an accepted response is discarded. There is no memory write, and the pointer and counter stay unchanged.
- R3: A ring response goes to index (pointer + 1) mod 256. The response word is written to base + 8·index and the extended word to base + 8·index + 4, in that order. Afterwards the pointer (register 2, bits 7:0) equals that index. The base is register 4, with its low 3 bits forced to zero.
- R4: The extended word holds the codec address in bits 3:0, holds 1 in bit 4 only for an unsolicited response, and holds zero in all other bits.
- R5: The response counter (register 7) increments by one after each completed ring entry and wraps at 256.
- R6: The interrupt status (bit 0 of register 1, also output irq_sts_o) sets when a ring entry completes with the interrupt enable (bit 1 of register 0) set and either condition true: the new count equals the threshold (register 3, bits 7:0), or cmd_ring_empty_i is high. It never sets while the enable is clear.
- R7: Writing register 2 with bit 15 set clears the write pointer to zero.
- R8: Writing 1 to bit 0 of register 1 clears the interrupt status and resets the counter to zero.
- R9: rsp_ready_o is low from the cycle after an accept until the extended word is granted. An ungranted memory request holds its address and data.
- R10: After reset the pointer, counter, interrupt status, immediate status, enables and mem_req_o are zero, and rsp_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsp_valid_i | input | 1 | Codec response offered |
| rsp_ready_o | output | 1 | Response accepted this cycle when valid |
| rsp_data_i | input | 32 | Response word |
| rsp_unsol_i | input | 1 | Response is unsolicited |
| rsp_cad_i | input | CAD_W | Codec address of the responder |
| cmd_ring_empty_i | input | 1 | Command ring has no entries left |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| mem_req_o | output | 1 | Memory write request |
| mem_gnt_i | input | 1 | Memory write accepted |
| mem_addr_o | output | ADDR_W | Byte address of the write |
| mem_data_o | output | 32 | Write data |
| irq_sts_o | output | 1 | Ring interrupt status |

## Verification
A table of six responses walks through every mix of solicited and unsolicited flag with codec addresses at both ends of the range. This separates the flag bit from the address bits in the extended word. Each entry is granted after a different delay, which shows that address and data hold while the request waits. The threshold is placed on the last table entry, so the interrupt must stay low for five entries and rise exactly on the sixth. Directed runs fill the ring to index 255 and confirm the wrap to index 0. They also separate the immediate path from the dropped-when-disabled path, since both stay off the memory port and only the register results differ. Finally, the drained-command-ring trigger is tried with the enable clear and then set.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  typedef enum logic [2:0] {
    RA_CTRL     = 3'd0,
    RA_STAT     = 3'd1,
    RA_WPTR     = 3'd2,
    RA_THRESH   = 3'd3,
    RA_BASE     = 3'd4,
    RA_IMM_STAT = 3'd5,
    RA_IMM_RESP = 3'd6,
    RA_COUNT    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_RSP  = 2'd1,
    WS_EXT  = 2'd2
  } wr_state_e;

  localparam int unsigned WPTR_RST_BIT = 15;
  localparam int unsigned UNSOL_BIT    = 4;
  localparam int unsigned IMM_CAD_LSB  = 4;
  localparam int unsigned ENTRY_SHIFT  = 3;
  localparam int unsigned EXT_OFFSET   = 4;
endpackage

// File: rtl/rrw_regs.sv
module rrw_regs
  import rrw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CAD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [IDX_W-1:0]  wp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_sts_i,
  input  logic              imm_load_i,
  input  logic [31:0]       rsp_data_i,
  input  logic [CAD_W-1:0]  rsp_cad_i,
  output logic              dma_en_o,
  output logic              irq_en_o,
  output logic [CNT_W-1:0]  thresh_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              imm_busy_o,
  output logic              wp_rst_o,
  output logic              irq_clr_o
);
  reg_addr_e         ra;
  logic              dma_en_q, irq_en_q, busy_q, valid_q;
  logic [CNT_W-1:0]  thresh_q;
  logic [ADDR_W-1:0] base_q;
  logic [CAD_W-1:0]  cad_q;
  logic [31:0]       resp_q;

  assign ra = reg_addr_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      thresh_q <= '0;
      base_q   <= '0;
      cad_q    <= '0;
      resp_q   <= '0;
    end else begin
      if (reg_we_i) begin
        case (ra)
          RA_CTRL: begin
            dma_en_q <= reg_wdata_i[0];
            irq_en_q <= reg_wdata_i[1];
          end
          RA_THRESH: thresh_q <= reg_wdata_i[CNT_W-1:0];
          RA_BASE:   base_q   <= {reg_wdata_i[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
          RA_IMM_STAT: begin
            if (reg_wdata_i[0]) busy_q  <= 1'b1;
            if (reg_wdata_i[1]) valid_q <= 1'b0;
          end
          default: ;
        endcase
      end
      // delivery of a response wins over a same-cycle software write
      if (imm_load_i) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        cad_q   <= rsp_cad_i;
        resp_q  <= rsp_data_i;
      end
    end
  end

  assign wp_rst_o  = reg_we_i && (ra == RA_WPTR) && reg_wdata_i[WPTR_RST_BIT];
  assign irq_clr_o = reg_we_i && (ra == RA_STAT) && reg_wdata_i[0];

  always_comb begin
    reg_rdata_o = '0;
    case (ra)
      RA_CTRL:     reg_rdata_o[1:0] = {irq_en_q, dma_en_q};
      RA_STAT:     reg_rdata_o[0] = irq_sts_i;
      RA_WPTR:     reg_rdata_o[IDX_W-1:0] = wp_i;
      RA_THRESH:   reg_rdata_o[CNT_W-1:0] = thresh_q;
      RA_BASE:     reg_rdata_o[ADDR_W-1:0] = base_q;
      RA_IMM_STAT: begin
        reg_rdata_o[0] = busy_q;
        reg_rdata_o[1] = valid_q;
        reg_rdata_o[IMM_CAD_LSB +: CAD_W] = cad_q;
      end
      RA_IMM_RESP: reg_rdata_o = resp_q;
      RA_COUNT:    reg_rdata_o[CNT_W-1:0] = cnt_i;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign dma_en_o   = dma_en_q;
  assign irq_en_o   = irq_en_q;
  assign thresh_o   = thresh_q;
  assign base_o     = base_q;
  assign imm_busy_o = busy_q;

  p_imm_deliver_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_load_i |=> (!busy_q && valid_q && cad_q == $past(rsp_cad_i)));
endmodule

// File: rtl/rrw_ring.sv
module rrw_ring
  import rrw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CAD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       rsp_data_i,
  input  logic              rsp_unsol_i,
  input  logic [CAD_W-1:0]  rsp_cad_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              irq_en_i,
  input  logic              cmd_empty_i,
  input  logic              wp_rst_i,
  input  logic              irq_clr_i,
  output logic              idle_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic [IDX_W-1:0]  wp_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_sts_o
);
  wr_state_e        state_q, state_d;
  logic [IDX_W-1:0] wp_q, idx_q;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic [31:0]      word_q, ext_q, ext_d;
  logic             irq_q, commit, set_irq;
  logic [ADDR_W-1:0] entry_off;

  always_comb begin
    ext_d = '0;
    ext_d[CAD_W-1:0] = rsp_cad_i;
    ext_d[UNSOL_BIT] = rsp_unsol_i;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE: if (start_i)   state_d = WS_RSP;
      WS_RSP:  if (mem_gnt_i) state_d = WS_EXT;
      WS_EXT:  if (mem_gnt_i) state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  assign commit   = (state_q == WS_EXT) && mem_gnt_i;
  assign cnt_base = irq_clr_i ? '0 : cnt_q;
  assign cnt_d    = commit ? cnt_base + CNT_W'(1) : cnt_base;
  assign set_irq  = commit && irq_en_i && ((cnt_d == thresh_i) || cmd_empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      wp_q    <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      ext_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start_i && state_q == WS_IDLE) begin
        idx_q  <= wp_q + IDX_W'(1);
        word_q <= rsp_data_i;
        ext_q  <= ext_d;
      end
      if (wp_rst_i)    wp_q <= '0;
      else if (commit) wp_q <= idx_q;
      if (set_irq)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign entry_off  = ADDR_W'(idx_q) << ENTRY_SHIFT;
  assign mem_addr_o = base_i + entry_off + ((state_q == WS_EXT) ? ADDR_W'(EXT_OFFSET) : '0);
  assign mem_data_o = (state_q == WS_EXT) ? ext_q : word_q;
  assign mem_req_o  = (state_q != WS_IDLE);
  assign idle_o     = (state_q == WS_IDLE);
  assign wp_o       = wp_q;
  assign cnt_o      = cnt_q;
  assign irq_sts_o  = irq_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  p_ext_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WS_RSP && mem_gnt_i) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(EXT_OFFSET)));
  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !irq_clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_irq_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_sts_o) |-> $past(irq_en_i));
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !commit) |=> (!irq_sts_o && cnt_q == '0));
endmodule

// File: rtl/response_ring_writer.sv
module response_ring_writer
  import rrw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned RING_DEPTH = 256,
  parameter int unsigned CAD_W      = 4,
  localparam int unsigned IDX_W     = $clog2(RING_DEPTH),
  localparam int unsigned CNT_W     = IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [31:0]       rsp_data_i,
  input  logic              rsp_unsol_i,
  input  logic [CAD_W-1:0]  rsp_cad_i,
  input  logic              cmd_ring_empty_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic              irq_sts_o
);
  logic              accept, imm_load, ring_start, idle;
  logic              dma_en, irq_en, imm_busy, wp_rst, irq_clr;
  logic [CNT_W-1:0]  thresh, cnt;
  logic [IDX_W-1:0]  wp;
  logic [ADDR_W-1:0] base;

  assign rsp_ready_o = idle;
  assign accept      = rsp_valid_i && idle;
  assign imm_load    = accept && imm_busy;
  assign ring_start  = accept && !imm_busy && dma_en;

  rrw_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .CAD_W(CAD_W)) i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .wp_i(wp), .cnt_i(cnt), .irq_sts_i(irq_sts_o),
    .imm_load_i(imm_load), .rsp_data_i, .rsp_cad_i,
    .dma_en_o(dma_en), .irq_en_o(irq_en), .thresh_o(thresh), .base_o(base),
    .imm_busy_o(imm_busy), .wp_rst_o(wp_rst), .irq_clr_o(irq_clr)
  );

  rrw_ring #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .CAD_W(CAD_W)) i_ring (
    .clk_i, .rst_ni, .start_i(ring_start), .rsp_data_i, .rsp_unsol_i, .rsp_cad_i,
    .base_i(base), .thresh_i(thresh), .irq_en_i(irq_en), .cmd_empty_i(cmd_ring_empty_i),
    .wp_rst_i(wp_rst), .irq_clr_i(irq_clr), .idle_o(idle),
    .mem_req_o, .mem_gnt_i, .mem_addr_o, .mem_data_o,
    .wp_o(wp), .cnt_o(cnt), .irq_sts_o
  );

  p_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !imm_busy && !dma_en) |=> !mem_req_o);
  p_no_accept_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rsp_ready_o);
  p_imm_no_mem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_load |=> !mem_req_o);
endmodule

// File: tb/test_response_ring_writer.sv
module test_response_ring_writer;
  localparam logic [31:0] BASE = 32'h0001_0000;
  // {expected ext[7:0], unsol, cad[3:0], data[31:0]}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {8'h00, 1'b0, 4'h0, 32'hA000_0001},
    {8'h13, 1'b1, 4'h3, 32'h1234_5678},
    {8'h0F, 1'b0, 4'hF, 32'hFFFF_FFFF},
    {8'h1F, 1'b1, 4'hF, 32'h0000_0000},
    {8'h10, 1'b1, 4'h0, 32'hDEAD_BEEF},
    {8'h09, 1'b0, 4'h9, 32'h0BAD_F00D}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        rsp_valid_i = 1'b0, rsp_unsol_i = 1'b0, cmd_ring_empty_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic [3:0]  rsp_cad_i = '0;
  logic        reg_we_i = 1'b0, mem_gnt_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        rsp_ready_o, mem_req_o, irq_sts_o;
  logic [31:0] reg_rdata_o, mem_addr_o, mem_data_o;
  int n_tests = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  response_ring_writer i_response_ring_writer (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic send_rsp(input logic [31:0] d, input logic u, input logic [3:0] c);
    rsp_valid_i = 1'b1; rsp_data_i = d; rsp_unsol_i = u; rsp_cad_i = c;
    while (!rsp_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    rsp_valid_i = 1'b0;
  endtask

  task automatic expect_mem(input string req, input logic [31:0] ea, input logic [31:0] ed,
                            input int dly);
    int t = 0;
    while (!mem_req_o && t < 20) begin @(negedge clk_i); t++; end
    check({req, " req"}, {31'd0, mem_req_o}, 32'd1);
    check({req, " addr"}, mem_addr_o, ea);
    check({req, " data"}, mem_data_o, ed);
    check("R9 ready low while pending", {31'd0, rsp_ready_o}, 32'd0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk_i);
      check("R9 addr held", mem_addr_o, ea);
      check("R9 data held", mem_data_o, ed);
    end
    mem_gnt_i = 1'b1;
    @(negedge clk_i);
    mem_gnt_i = 1'b0;
  endtask

  task automatic drain_mem();
    for (int w = 0; w < 2; w++) begin
      while (!mem_req_o) @(negedge clk_i);
      mem_gnt_i = 1'b1;
      @(negedge clk_i);
      mem_gnt_i = 1'b0;
    end
  endtask

  task automatic no_mem(input string req);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check(req, {31'd0, mem_req_o}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    reg_rd(3'd2, r); check("R10 wptr", r, 0);
    reg_rd(3'd7, r); check("R10 count", r, 0);
    reg_rd(3'd5, r); check("R10 imm status", r, 0);
    reg_rd(3'd0, r); check("R10 ctrl", r, 0);
    check("R10 irq", {31'd0, irq_sts_o}, 0);
    check("R10 ready", {31'd0, rsp_ready_o}, 1);
    check("R10 mem_req", {31'd0, mem_req_o}, 0);

    reg_wr(3'd4, BASE);
    reg_wr(3'd3, 32'd6);
    reg_wr(3'd0, 32'd3);
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      send_rsp(v[31:0], v[36], v[35:32]);
      expect_mem("R3 word", BASE + 32'(8 * (i + 1)), v[31:0], i % 3);
      expect_mem("R4 ext", BASE + 32'(8 * (i + 1)) + 4, {24'd0, v[44:37]}, (i + 1) % 3);
      reg_rd(3'd2, r); check("R3 wptr", r, 32'(i + 1));
      reg_rd(3'd7, r); check("R5 count", r, 32'(i + 1));
      check("R6 threshold irq", {31'd0, irq_sts_o}, (i == NV - 1) ? 32'd1 : 32'd0);
      check("R9 ready after", {31'd0, rsp_ready_o}, 1);
    end

    // R8 clear
    reg_wr(3'd1, 32'd1);
    check("R8 irq cleared", {31'd0, irq_sts_o}, 0);
    reg_rd(3'd7, r); check("R8 count cleared", r, 0);

    // R3 wrap
    reg_wr(3'd0, 32'd1);
    for (int k = 7; k < 256; k++) begin
      send_rsp(32'(k), 1'b0, 4'h1);
      drain_mem();
    end
    reg_rd(3'd2, r); check("R3 wptr 255", r, 255);
    send_rsp(32'h5A5A_0000, 1'b0, 4'h2);
    expect_mem("R3 wrap word", BASE, 32'h5A5A_0000, 0);
    expect_mem("R3 wrap ext", BASE + 4, 32'h02, 0);
    reg_rd(3'd2, r); check("R3 wptr wrapped", r, 0);
    reg_rd(3'd7, r); check("R5 count 250", r, 250);
    reg_wr(3'd1, 32'd1);
    reg_rd(3'd7, r); check("R8 count cleared again", r, 0);

    // R7 pointer reset
    send_rsp(32'h1111_1111, 1'b0, 4'h1);
    drain_mem();
    reg_rd(3'd2, r); check("R7 wptr before", r, 1);
    reg_wr(3'd2, 32'h0000_8000);
    reg_rd(3'd2, r); check("R7 wptr reset", r, 0);
    send_rsp(32'h2222_2222, 1'b1, 4'h4);
    expect_mem("R7 next word", BASE + 8, 32'h2222_2222, 1);
    expect_mem("R7 next ext", BASE + 12, 32'h14, 0);

    // R1 immediate
    reg_wr(3'd5, 32'd1);
    reg_rd(3'd5, r); check("R1 busy set", r, 1);
    send_rsp(32'hCAFE_0005, 1'b1, 4'h5);
    no_mem("R1 no memory write");
    reg_rd(3'd6, r); check("R1 imm response", r, 32'hCAFE_0005);
    reg_rd(3'd5, r); check("R1 imm status", r, 32'h52);
    reg_rd(3'd2, r); check("R1 wptr unchanged", r, 1);
    reg_wr(3'd5, 32'd2);
    reg_rd(3'd5, r); check("R1 valid cleared", r, 32'h50);

    // R2 drop
    reg_wr(3'd0, 32'd2);
    send_rsp(32'h3333_3333, 1'b0, 4'h6);
    no_mem("R2 no memory write");
    reg_rd(3'd2, r); check("R2 wptr unchanged", r, 1);
    reg_rd(3'd7, r); check("R2 count unchanged", r, 2);
    check("R2 irq unchanged", {31'd0, irq_sts_o}, 0);

    // R6 drained command ring
    reg_wr(3'd1, 32'd1);
    reg_wr(3'd3, 32'd200);
    reg_wr(3'd0, 32'd1);
    cmd_ring_empty_i = 1'b1;
    send_rsp(32'h4444_4444, 1'b0, 4'h7);
    drain_mem();
    check("R6 no irq when disabled", {31'd0, irq_sts_o}, 0);
    reg_wr(3'd0, 32'd3);
    send_rsp(32'h5555_5555, 1'b0, 4'h7);
    drain_mem();
    check("R6 empty-ring irq", {31'd0, irq_sts_o}, 1);
    reg_rd(3'd7, r); check("R5 count after empty", r, 2);
    cmd_ring_empty_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule